// File: doc/BRIEF.md
# Two-Wire Serial Slave with Auto-Incrementing Register Bank

This block sits on a two-wire serial bus (I2C) as a slave and exposes a bank of 8-bit registers, indexed 0x00 to 0x6C, to a bus master. Both bus lines are sampled through a two-stage synchronizer into the system clock domain. Bus START and STOP conditions are recognised as SDA edges while SCL is high. The slave never drives a line high: it only asserts a drive-enable that pulls the line low. Inside the chip, a combinational lookup port lets other logic read any register by index.

A write transaction is START, the 7-bit device address 0x33 with R/W=0, a pointer byte, and then any number of data bytes. Each data byte lands at the pointer, and the pointer then advances. A read transaction is START, the address with R/W=1, and then bytes streamed out from the current pointer. The pointer keeps its value between transactions, so a master normally sets it with a short write and then reads through a repeated START. After the byte at 0x6C the pointer returns to 0x00.

The byte-phase machine has these states: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_PTR`, `ST_PTR_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA` and `ST_RDATA_ACK`. Its transitions are as follows.
- START goes to `ST_ADDR` from any state, and STOP goes to `ST_IDLE` from any state.
- In `ST_ADDR`, an address mismatch on the eighth SCL rise goes to `ST_IDLE`. On a match, the following SCL fall goes to `ST_ADDR_ACK`.
- `ST_ADDR_ACK` moves on at the next SCL fall: to `ST_PTR` for a write, or to `ST_RDATA` for a read.
- `ST_PTR` goes to `ST_PTR_ACK`, and `ST_PTR_ACK` goes to `ST_WDATA`. `ST_WDATA` and `ST_WDATA_ACK` alternate. Each of these steps happens on an SCL fall.
- `ST_RDATA` goes to `ST_RDATA_ACK` on the SCL fall after its eighth bit.
- In `ST_RDATA_ACK`, SDA high at the SCL rise (a NACK) goes to `ST_IDLE`. Otherwise the next SCL fall returns to `ST_RDATA`.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave acknowledges a first byte whose upper seven bits equal 0x33 by holding SDA low through the ninth SCL pulse. Bit 0 of that byte selects the direction: 0 for a write, 1 for a read.
- R2: After an address byte with any other upper seven bits, the slave never pulls SDA low until the next START, and no register changes.
- R3: In a write, the byte after the address is acknowledged and loaded into the register pointer. No register is changed by that byte.
- R4: Each later write byte is acknowledged and stored at the pointer. The pointer then advances by one after that byte completes.
- R5: A pointer at 0x6C advances to 0x00, in both writes and reads. A pointer above 0x6C advances by one, and 0xFF rolls over to 0x00.
- R6: Read bytes come out most significant bit first, starting at the current pointer. The slave pulls SDA low only for 0 bits and keeps SDA steady while SCL is high. The pointer advances after each byte.
- R7: When the master answers a read byte with NACK, the slave releases SDA and drives nothing further in that transaction.
- R8: Writes to pointers above 0x6C are acknowledged but change no register. Reads from such pointers return 0x00.
- R9: A STOP or a repeated START aborts the current byte at any bit position, and a partly received byte is not written. The pointer keeps its value across transactions.
- R10: The SCL drive-enable output is never asserted.
- R11: The lookup port returns the register at `host_addr` for indices up to 0x6C and 0x00 above. Every register is 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull-low enable for SCL (held inactive) |
| sda_oe | output | 1 | Pull-low enable for SDA |
| host_addr | input | 8 | Register index for the on-chip lookup port |
| host_rdata | output | 8 | Register value at `host_addr` |

## Verification
The bench writes a computed pattern into every register and continues two bytes past 0x6C. It then reads one long burst that crosses 0x6C. A design that wraps at a power of two, or that advances the pointer before the byte completes, returns a shifted stream or overwrites 0x00 too early. Other cases target specific faults. A wrong-address transaction must leave SDA untouched; a slave that acknowledges it would also corrupt register 0. A burst into the range above 0x6C must change nothing; a slave that aliases the pointer would clobber low registers. A STOP in the middle of a byte must write nothing. A read that starts from a pointer left over from an earlier read catches a design that clears the pointer on STOP.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    // Idle bus is high, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl && !scl_prev;
    assign scl_fall  = !scl_lvl && scl_prev;
    assign start_det = scl_lvl && scl_prev && sda_prev && !sda_lvl;
    assign stop_det  = scl_lvl && scl_prev && !sda_prev && sda_lvl;

endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter int                NRD      = 2,
    parameter logic [ADDR_W-1:0] LAST_REG = 8'h6C
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [NRD-1:0][ADDR_W-1:0]    rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]    rd_data
);

    localparam int DEPTH = int'(LAST_REG) + 1;
    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && (wr_addr <= LAST_REG)) begin
            mem[wr_addr[IDX_W-1:0]] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_addr[p] <= LAST_REG) rd_data[p] = mem[rd_addr[p][IDX_W-1:0]];
            else                        rd_data[p] = '0;
        end
    end

endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
    import i2c_regbank_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [6:0]        DEV_ADDR = 7'h33,
    parameter logic [ADDR_W-1:0] LAST_REG = 8'h6C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] ptr,
    output logic [BYTE_W-1:0] wr_data
);

    phase_t            state, state_d;
    logic [2:0]        bit_cnt;
    logic              got8;
    logic              is_read;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic [BYTE_W-1:0] byte_in;
    logic              last_rise;
    logic              addr_hit;
    logic              shifting;
    logic [ADDR_W-1:0] ptr_next;

    assign byte_in   = {shreg[BYTE_W-2:0], sda_lvl};
    assign last_rise = scl_rise && (bit_cnt == 3'd7);
    assign addr_hit  = (byte_in[7:1] == DEV_ADDR);
    assign shifting  = (state == ST_ADDR) || (state == ST_PTR) ||
                       (state == ST_WDATA) || (state == ST_RDATA);
    assign ptr_next  = (ptr == LAST_REG) ? '0 : ptr + 1'b1;

    // Next-state logic
    always_comb begin
        state_d = state;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: begin
                    if (last_rise && !addr_hit)  state_d = ST_IDLE;
                    else if (scl_fall && got8)   state_d = ST_ADDR_ACK;
                end
                ST_ADDR_ACK: if (scl_fall) state_d = is_read ? ST_RDATA : ST_PTR;
                ST_PTR:       if (scl_fall && got8) state_d = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (scl_fall && got8) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && got8) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK: begin
                    if (scl_rise && sda_lvl) state_d = ST_IDLE;
                    else if (scl_fall)       state_d = ST_RDATA;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Byte datapath: bit counter, shifters, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            got8    <= 1'b0;
            is_read <= 1'b0;
            shreg   <= '0;
            txreg   <= '0;
            ptr     <= '0;
        end else begin
            if (start_det || stop_det) begin
                bit_cnt <= '0;
                got8    <= 1'b0;
            end else begin
                if (shifting && scl_rise) begin
                    bit_cnt <= bit_cnt + 3'd1;
                    shreg   <= byte_in;
                    if (bit_cnt == 3'd7) got8 <= 1'b1;
                end
                if (got8 && scl_fall) got8 <= 1'b0;
            end
            if ((state == ST_ADDR) && last_rise) is_read <= byte_in[0];
            if ((state == ST_PTR) && last_rise) begin
                ptr <= byte_in;
            end else if (((state == ST_WDATA) || (state == ST_RDATA)) && last_rise) begin
                ptr <= ptr_next;
            end
            if ((state_d == ST_RDATA) && (state != ST_RDATA)) begin
                txreg <= rd_data;
            end else if ((state == ST_RDATA) && scl_fall && !got8) begin
                txreg <= {txreg[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe  = 1'b0;
        wr_en   = 1'b0;
        wr_data = byte_in;
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = !txreg[BYTE_W-1];
            ST_WDATA: wr_en  = last_rise;
            default: ;
        endcase
    end

    // R9
    start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

    // R9
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R2
    addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR) && scl_rise && (bit_cnt == 3'd7) && (shreg[6:0] != DEV_ADDR))
        |=> ((state == ST_IDLE) && !sda_oe));

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == ST_WDATA) || (state == ST_RDATA)) && scl_rise &&
         (bit_cnt == 3'd7) && (ptr == LAST_REG)) |=> (ptr == '0));

    // R6
    tx_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RDATA) && scl_lvl && !start_det && !stop_det) |=> $stable(sda_oe));

    // R7
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RDATA_ACK) && scl_rise && sda_lvl && !start_det && !stop_det)
        |=> !sda_oe);

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
    parameter int                ADDR_W      = 8,
    parameter logic [6:0]        DEV_ADDR    = 7'h33,
    parameter logic [ADDR_W-1:0] LAST_REG    = 8'h6C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [7:0]        host_rdata
);

    localparam int NRD = 2;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic wr_en;
    logic [ADDR_W-1:0] ptr;
    logic [7:0] wr_data;
    logic [NRD-1:0][ADDR_W-1:0] rd_addr;
    logic [NRD-1:0][7:0] rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_byte_fsm #(
        .ADDR_W   (ADDR_W),
        .DEV_ADDR (DEV_ADDR),
        .LAST_REG (LAST_REG)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data[0]),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .ptr       (ptr),
        .wr_data   (wr_data)
    );

    assign rd_addr[0] = ptr;
    assign rd_addr[1] = host_addr;

    i2c_reg_array #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (8),
        .NRD      (NRD),
        .LAST_REG (LAST_REG)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign host_rdata = rd_data[1];
    assign scl_oe     = 1'b0;

endmodule

// File: tb/i2c_regbank_slave_tb.sv
module i2c_regbank_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 12;
    localparam logic [6:0] DEV = 7'h33;
    localparam logic [7:0] LAST = 8'h6C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic scl_oe, sda_oe;
    logic [7:0] host_addr = 8'h00;
    logic [7:0] host_rdata;
    logic scl_w, sda_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] model [256];
    logic [7:0] mptr = 8'h00;

    assign scl_w = scl_m & ~scl_oe;
    assign sda_w = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regbank_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_w),
        .sda_i      (sda_w),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .host_addr  (host_addr),
        .host_rdata (host_rdata)
    );

    function automatic logic [7:0] nxt(input logic [7:0] p);
        return (p == LAST) ? 8'h00 : p + 8'h01;
    endfunction

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic put_bit(input logic b);
        waitc(2); sda_m = b; waitc(HALF-2);
        scl_m = 1'b1; waitc(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        waitc(2); sda_m = 1'b1; waitc(HALF);
        scl_m = 1'b1; waitc(HALF);
        sda_m = 1'b0; waitc(HALF);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        waitc(2); sda_m = 1'b0; waitc(HALF);
        scl_m = 1'b1; waitc(HALF);
        sda_m = 1'b1; waitc(HALF);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        waitc(2); sda_m = 1'b1; waitc(HALF-2);
        scl_m = 1'b1; waitc(HALF/2);
        ack = !sda_w;
        waitc(HALF - HALF/2);
        scl_m = 1'b0;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            waitc(2); sda_m = 1'b1; waitc(HALF-2);
            scl_m = 1'b1; waitc(HALF/2);
            b[i] = sda_w;
            waitc(HALF - HALF/2);
            scl_m = 1'b0;
        end
        put_bit(!mack);
    endtask

    task automatic begin_write(input logic [7:0] p);
        logic ack;
        bus_start();
        write_byte({DEV, 1'b0}, ack);
        check(ack, "R1 write address ack", {7'd0, ack}, 8'h01);
        write_byte(p, ack);
        check(ack, "R3 pointer byte ack", {7'd0, ack}, 8'h01);
        mptr = p;
    endtask

    task automatic put_data(input logic [7:0] v);
        logic ack;
        write_byte(v, ack);
        check(ack, "R4 data byte ack", {7'd0, ack}, 8'h01);
        if (mptr <= LAST) model[mptr] = v;
        mptr = nxt(mptr);
    endtask

    task automatic begin_read();
        logic ack;
        bus_start();
        write_byte({DEV, 1'b1}, ack);
        check(ack, "R1 read address ack", {7'd0, ack}, 8'h01);
    endtask

    task automatic get_data(input logic mack, input string tag);
        logic [7:0] got, exp;
        read_byte(mack, got);
        exp = (mptr <= LAST) ? model[mptr] : 8'h00;
        check(got == exp, tag, got, exp);
        mptr = nxt(mptr);
    endtask

    task automatic host_sweep(input string tag);
        for (int a = 0; a < 256; a++) begin
            logic [7:0] exp;
            host_addr = a[7:0];
            waitc(1);
            exp = (a <= int'(LAST)) ? model[a] : 8'h00;
            check(host_rdata == exp, tag, host_rdata, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic drove;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        waitc(5);
        rst_n = 1'b1;
        waitc(5);

        // R11 reset contents, R10 idle outputs
        check(sda_oe == 1'b0, "R7 sda released after reset", {7'd0, sda_oe}, 8'h00);
        check(scl_oe == 1'b0, "R10 scl never driven", {7'd0, scl_oe}, 8'h00);
        host_sweep("R11 reset value");

        // R3 R4 simple write burst
        begin_write(8'h10);
        for (int i = 0; i < 5; i++) put_data(8'hA0 + 8'(i));
        bus_stop();
        host_sweep("R4 burst stored");

        // R5 write wrap across 0x6C
        begin_write(8'h6A);
        for (int i = 0; i < 5; i++) put_data(8'h50 + 8'(i * 3));
        bus_stop();
        host_sweep("R5 write wrap");

        // R8 writes above the last register ignored
        begin_write(8'h70);
        for (int i = 0; i < 3; i++) put_data(8'hEE);
        bus_stop();
        host_sweep("R8 out-of-range write ignored");
        // R8 reads above range return zero (pointer now 0x73)
        begin_read();
        get_data(1'b1, "R8 out-of-range read");
        get_data(1'b0, "R8 out-of-range read");
        bus_stop();

        // R5 R6 read wrap via pointer set + repeated start
        begin_write(8'h6B);
        begin_read();
        get_data(1'b1, "R6 read at pointer");
        get_data(1'b1, "R5 read at last");
        get_data(1'b1, "R5 read wrapped to zero");
        get_data(1'b0, "R6 read after wrap");
        // R7 no drive after NACK
        drove = 1'b0;
        for (int i = 0; i < 40; i++) begin
            waitc(1);
            if (sda_oe) drove = 1'b1;
        end
        check(!drove, "R7 released after NACK", {7'd0, drove}, 8'h00);
        bus_stop();

        // R9 pointer persists across transactions (now 0x02)
        begin_read();
        get_data(1'b0, "R9 pointer kept across stop");
        bus_stop();

        // R2 wrong device address
        bus_start();
        write_byte({7'h32, 1'b0}, ack);
        check(!ack, "R2 wrong address not acked", {7'd0, ack}, 8'h00);
        write_byte(8'h00, ack);
        check(!ack, "R2 later byte not acked", {7'd0, ack}, 8'h00);
        write_byte(8'hAA, ack);
        check(!ack, "R2 later byte not acked", {7'd0, ack}, 8'h00);
        bus_stop();
        host_sweep("R2 no change after wrong address");

        // R9 stop in the middle of a data byte
        begin_write(8'h20);
        put_data(8'h5A);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        host_sweep("R9 partial byte discarded");
        // R9 repeated start mid-byte, then new write goes through
        begin_write(8'h30);
        for (int i = 0; i < 3; i++) put_bit(1'b0);
        begin_write(8'h31);
        put_data(8'h3C);
        bus_stop();
        host_sweep("R9 repeated start abort");

        // R4 R5 R6 full sweep: every register plus two past the wrap
        begin_write(8'h00);
        for (int i = 0; i < 111; i++) put_data(8'((i * 37 + 11) & 8'hFF));
        bus_stop();
        host_sweep("R11 sweep lookup");
        begin_write(8'h00);
        begin_read();
        for (int i = 0; i < 112; i++) get_data(i != 111, "R6 sweep read");
        bus_stop();

        // R5 pointer above range rolls 0xFF to 0x00
        begin_write(8'hFF);
        put_data(8'h77);
        put_data(8'h66);
        bus_stop();
        host_sweep("R5 rollover from 0xFF");

        check(scl_oe == 1'b0, "R10 scl never driven", {7'd0, scl_oe}, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule